// File: doc/BRIEF.md
# Clock Failure Supervisor with NMI Generation

This block watches two raw indications from the clock subsystem: an oscillator-too-low detector and a PLL lock detector. It synchronizes both into the core clock domain and acts on their edges. Each failure updates a status flag. It may also set a sticky non-maskable interrupt flag toward the CPU. Whether it does depends on how the system clock is currently routed and on the mode the PLL is in.

A loss of lock that happens in normal PLL mode, or an oscillator failure while the PLL runs in prescaler mode from the external oscillator, forces the PLL into a hardware free-running fallback. That fallback overrides the bypass register until software writes prescaler mode again.

Software drives the control inputs as register fields:
- system clock source select
- PLL input select
- VCO bypass together with its write strobe
- two detection-restart pulses
- per-source NMI enables and clears

It reads the flags and the effective PLL mode back.

Top module: `clkfail_nmi_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after it, all status and NMI flags, `nmi_req` and the forced free-running state are 0. `pll_mode` is then 2'b00 if `vco_bypass` is 0 and 2'b01 if it is 1.
- R2: A rising edge of `osc_low_raw` sets `osc_low_flag` after the synchronizer. The flag is visible at the third rising clock edge after the input changes.
- R3: An oscillator-low event sets `nmi_flag_osc` only in two cases:
  - `sysclk_pll` = 0, meaning the oscillator drives the system clock directly;
  - `sysclk_pll` = 1 with the effective mode prescaler and `pll_in_osc` = 1, meaning the PLL input is the oscillator.
- R4: A rising edge of `lock_raw` sets `lock_flag`, and any later fall clears it. The fall sets `nmi_flag_pll` only when `sysclk_pll` = 1 and the effective mode is normal (`vco_bypass` = 0, not forced). In every other routing the fall only clears the lock flag.
- R5: Before `lock_flag` has been set once since reset, no loss-of-lock NMI and no forced free-running mode can occur.
- R6: `pll_mode` encodes the effective mode: 2'b00 normal, 2'b01 prescaler, 2'b10 free-running. Free-running is forced in two cases:
  - an oscillator-low event in prescaler mode with `pll_in_osc` = 1;
  - a loss of lock in normal mode.
- R7: Once forced, free-running holds even if `vco_bypass` changes. It ends only on a cycle with `bypass_wr` = 1 and `vco_bypass` = 1; `pll_mode` reads 2'b01 at the next edge.
- R8: The NMI flags are sticky. They clear only when `nmi_clr_osc` or `nmi_clr_pll` is pulsed, and a set in the same cycle wins over the clear. One sustained failure sets a flag exactly once.
- R9: `nmi_req` is 1 exactly when (`nmi_flag_osc` and `nmi_en_osc`) or (`nmi_flag_pll` and `nmi_en_pll`).
- R10: A `wdt_restart` pulse clears `osc_low_flag` and re-arms detection, so a condition that is still present sets the flag again one edge later. A `lock_restart` pulse does the same for `lock_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_low_raw | input | 1 | Asynchronous oscillator-too-low detector output, 1 = too low |
| lock_raw | input | 1 | Asynchronous PLL lock detector output, 1 = locked |
| sysclk_pll | input | 1 | System clock source, 1 = PLL output, 0 = oscillator |
| pll_in_osc | input | 1 | PLL reference select, 1 = external oscillator |
| vco_bypass | input | 1 | Bypass register value, 1 = prescaler mode |
| bypass_wr | input | 1 | Write strobe of the bypass register |
| wdt_restart | input | 1 | Pulse: restart oscillator detection |
| lock_restart | input | 1 | Pulse: restart lock detection |
| nmi_en_osc | input | 1 | Oscillator NMI enable |
| nmi_en_pll | input | 1 | Loss-of-lock NMI enable |
| nmi_clr_osc | input | 1 | Pulse: clear oscillator NMI flag |
| nmi_clr_pll | input | 1 | Pulse: clear loss-of-lock NMI flag |
| osc_low_flag | output | 1 | Oscillator-too-low status |
| lock_flag | output | 1 | PLL lock status |
| nmi_flag_osc | output | 1 | Sticky oscillator NMI flag |
| nmi_flag_pll | output | 1 | Sticky loss-of-lock NMI flag |
| nmi_req | output | 1 | NMI request to the CPU |
| pll_mode | output | 2 | Effective PLL mode |

## Verification
Several internal faults show up at the ports within a few cycles of a failure edge:
- a stale edge-history bit or a wrong qualification term gives a wrong NMI flag or a wrong `pll_mode`, three edges after the raw input moves;
- a forced-mode bit that clears too early shows as `pll_mode` leaving 2'b10 on the very next edge after a bypass write of 0;
- a lost has-locked history shows as a missing or spurious NMI on the first loss.

Random routings and bypass settings, crossed with both failure kinds, reach every qualification case. Directed sequences cover restart, clear and fallback release.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL   = 2'b00,
        MODE_PRESCALE = 2'b01,
        MODE_FREERUN  = 2'b10
    } pll_mode_e;

    typedef struct packed {
        logic osc_prev;
        logic lock_prev;
        logic osc_low;
        logic lock;
        logic has_locked;
        logic forced_fr;
        logic nmi_osc;
        logic nmi_pll;
    } sup_state_t;

endpackage

// File: rtl/cfs_sync.sv
module cfs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[0] <= '0;
                else        stg_q[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[i] <= '0;
                else        stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/cfs_route_qual.sv
module cfs_route_qual
    import cfs_pkg::*;
(
    input  pll_mode_e mode,
    input  logic      sysclk_pll,
    input  logic      pll_in_osc,
    output logic      osc_nmi_ok,
    output logic      osc_force_ok,
    output logic      pll_nmi_ok,
    output logic      pll_force_ok
);
    always_comb begin
        osc_force_ok = (mode == MODE_PRESCALE) && pll_in_osc;
        osc_nmi_ok   = !sysclk_pll || osc_force_ok;
        pll_force_ok = (mode == MODE_NORMAL);
        pll_nmi_ok   = sysclk_pll && pll_force_ok;
    end
endmodule

// File: rtl/clkfail_nmi_ctrl.sv
module clkfail_nmi_ctrl
    import cfs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_low_raw,
    input  logic       lock_raw,
    input  logic       sysclk_pll,
    input  logic       pll_in_osc,
    input  logic       vco_bypass,
    input  logic       bypass_wr,
    input  logic       wdt_restart,
    input  logic       lock_restart,
    input  logic       nmi_en_osc,
    input  logic       nmi_en_pll,
    input  logic       nmi_clr_osc,
    input  logic       nmi_clr_pll,
    output logic       osc_low_flag,
    output logic       lock_flag,
    output logic       nmi_flag_osc,
    output logic       nmi_flag_pll,
    output logic       nmi_req,
    output logic [1:0] pll_mode
);
    localparam int NRAW = 2;

    logic       osc_low_s, lock_s;
    sup_state_t st_d, st_q;
    pll_mode_e  mode_cur;
    logic       osc_nmi_ok, osc_force_ok, pll_nmi_ok, pll_force_ok;
    logic       osc_ev, lock_rise, lock_loss, force_set;

    cfs_sync #(.WIDTH(NRAW), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({osc_low_raw, lock_raw}),
        .q     ({osc_low_s, lock_s})
    );

    always_comb begin
        if (st_q.forced_fr)  mode_cur = MODE_FREERUN;
        else if (vco_bypass) mode_cur = MODE_PRESCALE;
        else                 mode_cur = MODE_NORMAL;
    end

    cfs_route_qual u_qual (
        .mode         (mode_cur),
        .sysclk_pll   (sysclk_pll),
        .pll_in_osc   (pll_in_osc),
        .osc_nmi_ok   (osc_nmi_ok),
        .osc_force_ok (osc_force_ok),
        .pll_nmi_ok   (pll_nmi_ok),
        .pll_force_ok (pll_force_ok)
    );

    always_comb begin
        st_d = st_q;

        osc_ev    = osc_low_s & ~st_q.osc_prev & ~wdt_restart;
        lock_rise = lock_s & ~st_q.lock_prev & ~lock_restart;
        lock_loss = ~lock_s & st_q.lock_prev & st_q.has_locked & ~lock_restart;
        force_set = (osc_ev & osc_force_ok) | (lock_loss & pll_force_ok);

        st_d.osc_prev  = wdt_restart  ? 1'b0 : osc_low_s;
        st_d.lock_prev = lock_restart ? 1'b0 : lock_s;

        if (wdt_restart) st_d.osc_low = 1'b0;
        else if (osc_ev) st_d.osc_low = 1'b1;

        if (lock_restart)   st_d.lock = 1'b0;
        else if (lock_rise) st_d.lock = 1'b1;
        else if (lock_loss) st_d.lock = 1'b0;

        if (lock_rise) st_d.has_locked = 1'b1;

        if (force_set)                    st_d.forced_fr = 1'b1;
        else if (bypass_wr && vco_bypass) st_d.forced_fr = 1'b0;

        if (osc_ev && osc_nmi_ok) st_d.nmi_osc = 1'b1;
        else if (nmi_clr_osc)     st_d.nmi_osc = 1'b0;

        if (lock_loss && pll_nmi_ok) st_d.nmi_pll = 1'b1;
        else if (nmi_clr_pll)        st_d.nmi_pll = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign osc_low_flag = st_q.osc_low;
    assign lock_flag    = st_q.lock;
    assign nmi_flag_osc = st_q.nmi_osc;
    assign nmi_flag_pll = st_q.nmi_pll;
    assign nmi_req      = (st_q.nmi_osc & nmi_en_osc) | (st_q.nmi_pll & nmi_en_pll);
    assign pll_mode     = mode_cur;
endmodule

// File: rtl/cfs_chk.sv
module cfs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sysclk_pll,
    input logic       pll_in_osc,
    input logic       vco_bypass,
    input logic       bypass_wr,
    input logic       nmi_clr_osc,
    input logic       nmi_clr_pll,
    input logic       lock_flag,
    input logic       nmi_flag_osc,
    input logic       nmi_flag_pll,
    input logic [1:0] pll_mode
);
    // R6
    mode_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_mode != 2'b11);

    // R7
    freerun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_mode == 2'b10 && !(bypass_wr && vco_bypass)) |=> pll_mode == 2'b10);

    // R8
    osc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_flag_osc && !nmi_clr_osc) |=> nmi_flag_osc);

    // R8
    pll_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_flag_pll && !nmi_clr_pll) |=> nmi_flag_pll);

    // R3
    osc_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_flag_osc) |-> (!$past(sysclk_pll) || ($past(vco_bypass) && $past(pll_in_osc))));

    // R4
    pll_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_flag_pll) |-> ($past(sysclk_pll) && !$past(vco_bypass) && !lock_flag));
endmodule

bind clkfail_nmi_ctrl cfs_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sysclk_pll   (sysclk_pll),
    .pll_in_osc   (pll_in_osc),
    .vco_bypass   (vco_bypass),
    .bypass_wr    (bypass_wr),
    .nmi_clr_osc  (nmi_clr_osc),
    .nmi_clr_pll  (nmi_clr_pll),
    .lock_flag    (lock_flag),
    .nmi_flag_osc (nmi_flag_osc),
    .nmi_flag_pll (nmi_flag_pll),
    .pll_mode     (pll_mode)
);

// File: tb/tb_clkfail_nmi_ctrl.sv
`timescale 1ns/1ps
module tb_clkfail_nmi_ctrl;
    logic clk = 1'b0;
    logic rst_n;
    logic osc_low_raw, lock_raw, sysclk_pll, pll_in_osc, vco_bypass, bypass_wr;
    logic wdt_restart, lock_restart, nmi_en_osc, nmi_en_pll, nmi_clr_osc, nmi_clr_pll;
    logic osc_low_flag, lock_flag, nmi_flag_osc, nmi_flag_pll, nmi_req;
    logic [1:0] pll_mode;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    clkfail_nmi_ctrl dut (
        .clk(clk), .rst_n(rst_n), .osc_low_raw(osc_low_raw), .lock_raw(lock_raw),
        .sysclk_pll(sysclk_pll), .pll_in_osc(pll_in_osc), .vco_bypass(vco_bypass),
        .bypass_wr(bypass_wr), .wdt_restart(wdt_restart), .lock_restart(lock_restart),
        .nmi_en_osc(nmi_en_osc), .nmi_en_pll(nmi_en_pll), .nmi_clr_osc(nmi_clr_osc),
        .nmi_clr_pll(nmi_clr_pll), .osc_low_flag(osc_low_flag), .lock_flag(lock_flag),
        .nmi_flag_osc(nmi_flag_osc), .nmi_flag_pll(nmi_flag_pll), .nmi_req(nmi_req),
        .pll_mode(pll_mode)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        osc_low_raw = 0; lock_raw = 0; sysclk_pll = 0; pll_in_osc = 0; vco_bypass = 0;
        bypass_wr = 0; wdt_restart = 0; lock_restart = 0; nmi_en_osc = 0; nmi_en_pll = 0;
        nmi_clr_osc = 0; nmi_clr_pll = 0;
        step(4);
        rst_n = 1'b1;
    endtask

    function automatic logic exp_osc_nmi(logic sys, logic pin, logic byp);
        return !sys || (byp && pin);
    endfunction

    function automatic logic [1:0] exp_mode_osc(logic pin, logic byp);
        if (byp && pin) return 2'b10;
        return byp ? 2'b01 : 2'b00;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset();
        // R1 reset state
        check("R1 osc_low_flag", osc_low_flag, 0);
        check("R1 lock_flag", lock_flag, 0);
        check("R1 nmi flags", {nmi_flag_osc, nmi_flag_pll, nmi_req}, 0);
        check("R1 mode", pll_mode, 2'b00);

        // R5 no loss-of-lock action before first lock
        sysclk_pll = 1;
        step(10);
        check("R5 no pll nmi", nmi_flag_pll, 0);
        check("R5 no freerun", pll_mode, 2'b00);

        // R2 latency, R8 once, R9 enable gating
        do_reset();
        osc_low_raw = 1;
        step(2);
        check("R2 not yet", osc_low_flag, 0);
        step(1);
        check("R2 flag set", osc_low_flag, 1);
        check("R3 osc nmi direct", nmi_flag_osc, 1);
        check("R9 disabled", nmi_req, 0);
        nmi_en_osc = 1;
        step(0);
        check("R9 enabled", nmi_req, 1);
        nmi_clr_osc = 1; step(1); nmi_clr_osc = 0;
        step(8);
        check("R8 cleared once", nmi_flag_osc, 0);
        check("R9 cleared", nmi_req, 0);

        // R10 watchdog restart while still low
        wdt_restart = 1; step(1); wdt_restart = 0;
        check("R10 osc restart clear", osc_low_flag, 0);
        step(1);
        check("R10 osc re-set", osc_low_flag, 1);
        check("R8 re-armed nmi", nmi_flag_osc, 1);
        osc_low_raw = 0; step(3);
        wdt_restart = 1; step(1); wdt_restart = 0;
        step(4);
        check("R10 osc stays clear", osc_low_flag, 0);

        // R10 lock restart while locked
        lock_raw = 1; step(4);
        check("R4 locked", lock_flag, 1);
        lock_restart = 1; step(1); lock_restart = 0;
        check("R10 lock restart clear", lock_flag, 0);
        step(1);
        check("R10 lock re-set", lock_flag, 1);

        // R6 / R7 freerun via loss in normal mode, release rule
        do_reset();
        sysclk_pll = 1; nmi_en_pll = 1;
        lock_raw = 1; step(4);
        lock_raw = 0; step(4);
        check("R4 pll nmi", nmi_flag_pll, 1);
        check("R9 pll req", nmi_req, 1);
        check("R6 freerun", pll_mode, 2'b10);
        bypass_wr = 1; step(1); bypass_wr = 0;
        check("R7 write 0 holds", pll_mode, 2'b10);
        vco_bypass = 1; step(2);
        check("R7 no write holds", pll_mode, 2'b10);
        bypass_wr = 1; step(1); bypass_wr = 0;
        check("R7 released", pll_mode, 2'b01);
        nmi_clr_pll = 1; step(1); nmi_clr_pll = 0;
        check("R8 pll clear", nmi_flag_pll, 0);

        // randomized routing crossed with failure kind
        for (int t = 0; t < 60; t++) begin
            logic sys, pin, byp, eo, ep, kind;
            sys = 1'($urandom); pin = 1'($urandom); byp = 1'($urandom);
            eo = 1'($urandom); ep = 1'($urandom); kind = 1'($urandom);
            do_reset();
            sysclk_pll = sys; pll_in_osc = pin; vco_bypass = byp;
            nmi_en_osc = eo; nmi_en_pll = ep;
            step(2);
            lock_raw = 1; step(4);
            check("R4 rand lock", lock_flag, 1);
            if (kind) begin
                osc_low_raw = 1; step(4);
                check("R2 rand osc flag", osc_low_flag, 1);
                check("R3 rand osc nmi", nmi_flag_osc, exp_osc_nmi(sys, pin, byp));
                check("R6 rand osc mode", pll_mode, exp_mode_osc(pin, byp));
                check("R9 rand req", nmi_req, exp_osc_nmi(sys, pin, byp) & eo);
            end else begin
                lock_raw = 0; step(4);
                check("R4 rand lock clr", lock_flag, 0);
                check("R4 rand pll nmi", nmi_flag_pll, sys && !byp);
                check("R6 rand loss mode", pll_mode, byp ? 2'b01 : 2'b10);
                check("R9 rand req", nmi_req, (sys && !byp) & ep);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule